// File: doc/BRIEF.md
# Unaligned Operand Bus Splitter

This block sits between a processor core and a 32-bit external bus on which every transfer addresses a whole, word-aligned location and selects bytes with four active-low lane enables. The core asks for a read or a write of a 1, 2 or 4 byte operand at any byte address. The block turns each request into one or two bus cycles. The bus moves byte k of the operand on the lane given by its address, and read bytes come back right-justified.

An operand that fits inside one word needs one bus cycle. An operand that runs past a word boundary needs two. The cycle that covers the following word, which carries the operand's high-order bytes, always goes out first. The cycle that covers the starting word comes second. Each bus cycle uses a valid/ready handshake. When the last cycle is accepted, the block raises a one-cycle done pulse, and for reads it also presents the assembled operand.

Top module: `operand_splitter`

## Requirements
- R1: Every bus cycle drives a word address equal to a request byte address with its two low bits cleared. An operand whose offset plus length is at most 4 takes exactly one bus cycle, at the request's own word, with lanes offset through offset+length-1 enabled (bus_be_n bit i low means lane i, bits 8i+7:8i, is enabled).
- R2: An operand whose offset plus length exceeds 4 takes two bus cycles. The first goes to the next word (aligned address + 4) with lanes 0 through offset+length-5 enabled. The second goes to the starting word with lanes offset through 3 enabled.
- R3: req_size encodes the operand length: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 both mean 4 bytes.
- R4: In a write cycle, operand byte k (req_wdata bits 8k+7:8k) appears on lane (offset+k) mod 4. Lanes that are not enabled carry zero, and bus_wdata is all zero in read cycles. bus_write follows req_write.
- R5: After a read, byte k of rdata equals the bus byte read from address req_addr+k for k below the length. Higher bytes are zero. After a write, rdata is zero.
- R6: While bus_valid is high and bus_ready is low, bus_addr, bus_be_n, bus_wdata and bus_write hold their values. A second bus cycle is presented only after the first has been accepted.
- R7: done pulses for exactly one cycle, in the cycle after the edge at which the last bus cycle is accepted. busy is high from the cycle after a request is accepted until that done cycle, and is low during it.
- R8: A request is taken only while busy is low. A req_valid raised while busy is high has no effect on the bus cycles or the result.
- R9: A synchronous active-high rst clears bus_valid, busy and done, dropping any bus cycle in progress.
- R10: The enabled lanes of any bus cycle are never empty and always form one contiguous group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 8*LANES | Right-justified write operand |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8*LANES | Right-justified read result, valid with done |
| bus_valid | output | 1 | Bus cycle presented |
| bus_ready | input | 1 | Bus accepts the presented cycle |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be_n | output | LANES | Active-low lane enables |
| bus_wdata | output | 8*LANES | Lane-positioned write data |
| bus_rdata | input | 8*LANES | Read data, sampled with bus_ready |

## Verification
A wrong phase or a wrong stored second-cycle plan shows on the bus at once. The next presented cycle carries the wrong word address or the wrong enable pattern, or a single-word operand produces a second cycle. A wrong offset or length held for read placement does not show until done, when rdata holds bytes in the wrong positions or nonzero upper bytes. A lost stall hold shows in the very next stalled cycle as a changed address, enable or data. The sweep covers every offset, every length code, both directions, and several stall lengths at two base addresses, so every split pattern is seen both with and without back-pressure.

// File: rtl/opsplit_pkg.sv
package opsplit_pkg;

  // Controller phase: idle, presenting the first of two cycles, presenting the final cycle.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LAST  = 2'd2
  } phase_e;

  // Length code to byte count: 0 -> 1, 1 -> 2, 2 and 3 -> 4.
  function automatic logic [3:0] code_to_len(input logic [1:0] code);
    case (code)
      2'd0:    code_to_len = 4'd1;
      2'd1:    code_to_len = 4'd2;
      default: code_to_len = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/opsplit_plan.sv
// Decodes a byte address and length code into the lane masks and word
// addresses of the starting word and of the following word.
module opsplit_plan #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_code,
  output logic [OFF_W-1:0]  off,
  output logic [LEN_W-1:0]  len,
  output logic              split,
  output logic [LANES-1:0]  mask_lo,
  output logic [LANES-1:0]  mask_hi,
  output logic [ADDR_W-1:0] word_lo,
  output logic [ADDR_W-1:0] word_hi
);
  import opsplit_pkg::*;

  logic [2*LANES-1:0] span;
  logic [2*LANES-1:0] ones;
  logic [3:0]         len4;

  always_comb begin
    off     = addr[OFF_W-1:0];
    len4    = code_to_len(size_code);
    len     = LEN_W'(len4);
    ones    = ((2*LANES)'(1) << len) - (2*LANES)'(1);
    span    = ones << off;
    mask_lo = span[LANES-1:0];
    mask_hi = span[2*LANES-1:LANES];
    split   = |mask_hi;
    word_lo = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    word_hi = word_lo + ADDR_W'(LANES);
  end

endmodule

// File: rtl/opsplit_wroute.sv
// Places operand bytes onto the lanes that match their addresses; lanes
// outside the mask, and all lanes when not writing, are driven to zero.
module opsplit_wroute #(
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES
) (
  input  logic [DW-1:0]    opnd,
  input  logic [OFF_W-1:0] off,
  input  logic [LANES-1:0] mask,
  input  logic             wr_en,
  output logic [DW-1:0]    lanes_out
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFF_W-1:0] LJ = OFF_W'(j);
    logic [OFF_W-1:0] src;
    assign src = LJ - off;
    assign lanes_out[8*j +: 8] = (wr_en && mask[j]) ? opnd[8*src +: 8] : 8'h00;
  end
endmodule

// File: rtl/opsplit_rplace.sv
// Computes the next read accumulator: each operand byte that belongs to
// the current bus cycle is taken from the lane its address selects.
module opsplit_rplace #(
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int LEN_W = OFF_W + 1,
  localparam int DW    = 8 * LANES
) (
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    bus_bytes,
  input  logic [OFF_W-1:0] off,
  input  logic [LEN_W-1:0] len,
  input  logic             upper,
  input  logic             capture,
  output logic [DW-1:0]    acc_next
);
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    localparam logic [LEN_W-1:0] KK = LEN_W'(k);
    logic [LEN_W-1:0] pos;
    logic             take;
    assign pos  = {1'b0, off} + KK;
    assign take = capture && (KK < len) && (pos[OFF_W] == upper);
    assign acc_next[8*k +: 8] = take ? bus_bytes[8*pos[OFF_W-1:0] +: 8] : acc[8*k +: 8];
  end
endmodule

// File: rtl/operand_splitter.sv
// Splits byte-addressed operand requests into word-aligned bus cycles,
// high-order word first, and assembles read results.
module operand_splitter #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int LEN_W = OFF_W + 1,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be_n,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata
);
  import opsplit_pkg::*;

  // Decode of the incoming request
  logic [OFF_W-1:0]  p_off;
  logic [LEN_W-1:0]  p_len;
  logic              p_split;
  logic [LANES-1:0]  p_mask_lo, p_mask_hi;
  logic [ADDR_W-1:0] p_word_lo, p_word_hi;
  logic [DW-1:0]     w_lo, w_hi;

  // Controller state
  phase_e            ph_q;
  logic              valid_q, write_q, done_q, upper_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr_q;
  logic [LANES-1:0]  be_n_q, nxt_be_n_q;
  logic [DW-1:0]     wdata_q, nxt_wdata_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [DW-1:0]     acc_q, acc_nx;
  logic              take_req, bus_fire;

  opsplit_plan #(.ADDR_W(ADDR_W), .LANES(LANES)) u_plan (
    .addr(req_addr), .size_code(req_size),
    .off(p_off), .len(p_len), .split(p_split),
    .mask_lo(p_mask_lo), .mask_hi(p_mask_hi),
    .word_lo(p_word_lo), .word_hi(p_word_hi)
  );

  opsplit_wroute #(.LANES(LANES)) u_wr_lo (
    .opnd(req_wdata), .off(p_off), .mask(p_mask_lo), .wr_en(req_write), .lanes_out(w_lo)
  );

  opsplit_wroute #(.LANES(LANES)) u_wr_hi (
    .opnd(req_wdata), .off(p_off), .mask(p_mask_hi), .wr_en(req_write), .lanes_out(w_hi)
  );

  opsplit_rplace #(.LANES(LANES)) u_rd (
    .acc(acc_q), .bus_bytes(bus_rdata), .off(off_q), .len(len_q),
    .upper(upper_q), .capture(!write_q), .acc_next(acc_nx)
  );

  assign take_req = (ph_q == PH_IDLE) && req_valid;
  assign bus_fire = valid_q && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      valid_q     <= 1'b0;
      done_q      <= 1'b0;
      write_q     <= 1'b0;
      upper_q     <= 1'b0;
      addr_q      <= '0;
      be_n_q      <= '1;
      wdata_q     <= '0;
      nxt_addr_q  <= '0;
      nxt_be_n_q  <= '1;
      nxt_wdata_q <= '0;
      off_q       <= '0;
      len_q       <= '0;
      acc_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (take_req) begin
            valid_q     <= 1'b1;
            write_q     <= req_write;
            off_q       <= p_off;
            len_q       <= p_len;
            acc_q       <= '0;
            nxt_addr_q  <= p_word_lo;
            nxt_be_n_q  <= ~p_mask_lo;
            nxt_wdata_q <= w_lo;
            if (p_split) begin
              addr_q  <= p_word_hi;
              be_n_q  <= ~p_mask_hi;
              wdata_q <= w_hi;
              upper_q <= 1'b1;
              ph_q    <= PH_FIRST;
            end else begin
              addr_q  <= p_word_lo;
              be_n_q  <= ~p_mask_lo;
              wdata_q <= w_lo;
              upper_q <= 1'b0;
              ph_q    <= PH_LAST;
            end
          end
        end
        PH_FIRST: begin
          if (bus_fire) begin
            acc_q   <= acc_nx;
            addr_q  <= nxt_addr_q;
            be_n_q  <= nxt_be_n_q;
            wdata_q <= nxt_wdata_q;
            upper_q <= 1'b0;
            ph_q    <= PH_LAST;
          end
        end
        PH_LAST: begin
          if (bus_fire) begin
            acc_q   <= acc_nx;
            valid_q <= 1'b0;
            done_q  <= 1'b1;
            ph_q    <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign rdata     = acc_q;
  assign bus_valid = valid_q;
  assign bus_write = write_q;
  assign bus_addr  = addr_q;
  assign bus_be_n  = be_n_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/opsplit_checker.sv
module opsplit_checker #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_be_n,
  input logic [DW-1:0]     bus_wdata
);

  function automatic logic one_run(input logic [LANES-1:0] m);
    int starts;
    starts = 0;
    for (int i = 0; i < LANES; i++)
      if (m[i] && (i == 0 || !m[(i == 0) ? 0 : i-1])) starts++;
    return starts == 1;
  endfunction

  function automatic logic [DW-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_addr[OFF_W-1:0] == '0)); // R1

  AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> one_run(~bus_be_n)); // R10

  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ((bus_wdata & ~lane_bits(~bus_be_n)) == '0)); // R4

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be_n)
                                   && $stable(bus_wdata) && $stable(bus_write))); // R6

  AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_valid && bus_ready)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_valid); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_valid && !busy && !done)); // R9

endmodule

bind operand_splitter opsplit_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_opsplit_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata)
);

// File: tb/operand_splitter_bench.sv
`timescale 1ns/1ps
module operand_splitter_bench;
  localparam int ADDR_W = 32;
  localparam int LANES  = 4;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              busy, done, bus_valid, bus_write;
  logic              bus_ready = 1'b0;
  logic [DW-1:0]     rdata, bus_wdata, bus_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [LANES-1:0]  bus_be_n;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  operand_splitter #(.ADDR_W(ADDR_W), .LANES(LANES)) u_operand_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Bus memory model: each byte a function of its address.
  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb
    for (int j = 0; j < LANES; j++) bus_rdata[8*j +: 8] = mem_byte(bus_addr + ADDR_W'(j));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  // One request with a given stall per bus cycle.
  task automatic run_op(input logic [ADDR_W-1:0] addr, input logic [1:0] code,
                        input bit wr, input int stall, input logic [DW-1:0] wd);
    int n, off, nph, wait_cnt;
    logic [ADDR_W-1:0] word;
    logic [LANES-1:0]  exp_be_n;
    logic [DW-1:0]     exp_wd, exp_rd;
    n   = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;   // R3
    off = int'(addr[1:0]);
    nph = (off + n > 4) ? 2 : 1;
    @(negedge clk);
    check(busy == 1'b0, "R8 idle before request", 64'(busy), 64'(0));
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = code; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'(1));
    for (int p = 0; p < nph; p++) begin
      word = {addr[ADDR_W-1:2], 2'b00} + ((nph == 2 && p == 0) ? ADDR_W'(4) : ADDR_W'(0));
      exp_wd = '0;
      for (int j = 0; j < LANES; j++) begin
        int k;
        k = int'(word) + j - int'(addr);
        exp_be_n[j] = !(k >= 0 && k < n);
        if (wr && k >= 0 && k < n) exp_wd[8*j +: 8] = wd[8*k +: 8];
      end
      wait_cnt = 0;
      while (!bus_valid && wait_cnt < 50) begin @(negedge clk); wait_cnt++; end
      check(bus_valid == 1'b1, "R6 bus cycle presented", 64'(bus_valid), 64'(1));
      check(bus_addr == word, (nph == 2) ? "R2 split word address" : "R1 word address",
            64'(bus_addr), 64'(word));
      check(bus_be_n == exp_be_n, (nph == 2) ? "R2 split lane enables" : "R1 lane enables",
            64'(bus_be_n), 64'(exp_be_n));
      check(bus_wdata == exp_wd, "R4 lane write data", 64'(bus_wdata), 64'(exp_wd));
      check(bus_write == wr, "R4 bus direction", 64'(bus_write), 64'(wr));
      for (int s = 0; s < stall; s++) begin
        if (p == 0 && s == 0) begin
          req_valid = 1'b1; req_addr = addr + 32'd9; req_size = 2'd2; req_write = !wr; req_wdata = ~wd;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_valid && bus_addr == word && bus_be_n == exp_be_n && bus_wdata == exp_wd,
              "R6 hold while stalled", 64'(bus_addr), 64'(word));
      end
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
    end
    exp_rd = '0;
    if (!wr) for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = mem_byte(addr + ADDR_W'(k));
    check(done == 1'b1, "R7 done pulse", 64'(done), 64'(1));
    check(busy == 1'b0, "R7 busy low with done", 64'(busy), 64'(0));
    check(bus_valid == 1'b0, (nph == 2) ? "R2 no third cycle" : "R1 single cycle only",
          64'(bus_valid), 64'(0));
    check(rdata == exp_rd, "R5 assembled result", 64'(rdata), 64'(exp_rd));
    @(negedge clk);
    check(done == 1'b0, "R7 done lasts one cycle", 64'(done), 64'(0));
    check(bus_valid == 1'b0, "R8 no stray request taken", 64'(bus_valid), 64'(0));
  endtask

  initial begin
    logic [ADDR_W-1:0] bases [2];
    int idx;
    bases[0] = 32'h0000_1000;
    bases[1] = 32'h0002_ABC0;
    idx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_valid && !busy && !done, "R9 reset state", {61'd0, bus_valid, busy, done}, 64'd0);
    for (int b = 0; b < 2; b++)
      for (int off = 0; off < 4; off++)
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++) begin
              idx++;
              run_op(bases[b] + ADDR_W'(off), 2'(c), w[0], s, 32'h1122_3344 ^ (32'(idx) * 32'h0101_0101));
            end
    // Reset in the middle of a stalled split cycle.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_1003; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(bus_valid == 1'b1, "R9 cycle pending before reset", 64'(bus_valid), 64'(1));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!bus_valid && !busy && !done, "R9 reset drops cycle", {61'd0, bus_valid, busy, done}, 64'd0);
    @(negedge clk);
    check(!bus_valid, "R9 nothing resumes", 64'(bus_valid), 64'd0);
    run_op(32'h0000_2002, 2'd1, 1'b0, 1, 32'h0);
    finish_run();
  end
endmodule